// File: doc/BRIEF.md
# Host Control Register Bank with Grouped Auto-Increment

This block holds the byte-wide control registers of a video and text decoder. A host loads a register address and then streams data bytes. After each data byte, read or written, the address pointer moves to the next register on its own. It only moves inside three fixed groups, and it parks on the last register of a group. The page-request data register at address 3 is an exception. The pointer never leaves it. Each byte written there is instead stored in a page-request entry chosen by a column index. That index starts from the start column held in register 2 and advances by one on every such write.

Bit 0 of register 0 selects which of two registers appears at address 11: the primary register or an alternate one. Some bit positions are reserved and always read back as zero. The registers come out of reset with a fixed pattern that is not all zeros. All register contents are driven out as a flat vector so that the decoder logic can use them. The page-request entries are driven out the same way.

Top module: `ctrl_regbank`

## Requirements
- R1: After a data byte (wr_en or rd_en without addr_ld), the pointer moves up by one while it is below the top of its group. The groups are 0..3, 4..7 and 8..G2_TOP, where G2_TOP is 12 or 13.
- R2: A data byte at a group top (3, 7, G2_TOP) leaves the pointer unchanged, so repeated bytes at address 3 all land on address 3. A pointer above G2_TOP also stays where it is.
- R3: Reset (rst_n low) loads 0x03 into registers 1, 5 and 6 and 0x00 into every other register, the alternate register and all page-request entries.
- R4: Each write at address 3 stores the masked byte into entry[col] and then increments col, wrapping from NCOL-1 to 0. Register 3 holds the last such byte.
- R5: Reserved bits are stored as 0 whatever value is written: bit 7 of register 1, bit 3 of register 2, and bits 7:5 of register 3 and of the page-request entries.
- R6: When bit 0 of register 0 is 0, reads and writes at address 11 use the primary register. When it is 1, they use the alternate register, and the primary register keeps its value.
- R7: addr_ld sets the pointer to addr_in and reloads col from bits 2:0 of register 2. A write to register 2 also reloads col, from bits 2:0 of the byte written.
- R8: At addresses 14 and 15, writes change no register, alternate register or entry, and reads return 0x00.
- R9: rd_data shows the register at the current pointer in the same cycle. A write becomes visible on the outputs after the clock edge that takes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_ld | input | 1 | Load register address strobe |
| addr_in | input | 4 | Register address to load |
| wr_en | input | 1 | Write data byte strobe |
| wr_data | input | 8 | Data byte to write |
| rd_en | input | 1 | Read data byte strobe (advances pointer) |
| rd_data | output | 8 | Register at current pointer |
| cfg_flat | output | 112 | All registers; register i at bits [8i+7:8i] |
| alt11_q | output | 8 | Alternate register for address 11 |
| pr_flat | output | 64 | Page-request entries; entry j at bits [8j+7:8j] |

## Verification
rd_data is combinational from the pointer. It is therefore due in the same cycle as rd_en, and the monitor compares it on the falling edge of that cycle, popping the value the driver queued. A write, an address load or a column step takes effect at the rising edge that ends the strobe cycle. Register and entry checks are therefore sampled one time unit after that edge. Pointer movement is always observed through later reads.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
  localparam int DW = 8;
  localparam int AW = 4;
  localparam int A_PAGE = 2;
  localparam int A_PRD  = 3;
  localparam int A_ALT  = 11;

  function automatic logic [DW-1:0] wmask(input int idx);
    case (idx)
      1:       return 8'h7F;
      2:       return 8'hF7;
      3:       return 8'h1F;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [DW-1:0] rst_val(input int idx);
    if (idx == 1 || idx == 5 || idx == 6) return 8'h03;
    return 8'h00;
  endfunction

  function automatic logic [AW-1:0] grp_top(input logic [AW-1:0] p, input int g2);
    if (p < AW'(4))       return AW'(3);
    if (p < AW'(8))       return AW'(7);
    if (p <= AW'(g2))     return AW'(g2);
    return p;
  endfunction
endpackage

// File: rtl/rb_pointer.sv
module rb_pointer
  import regbank_pkg::*;
#(
  parameter int G2_TOP = 13,
  parameter int CW     = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          addr_ld,
  input  logic [AW-1:0] addr_in,
  input  logic          wr_acc,
  input  logic          rd_acc,
  input  logic [DW-1:0] wr_data,
  input  logic [CW-1:0] r2_sc,
  output logic [AW-1:0] ptr,
  output logic [CW-1:0] col
);
  logic [AW-1:0] ptr_n;
  logic [CW-1:0] col_n;
  logic          step;
  logic [AW-1:0] top;

  assign step = wr_acc | rd_acc;
  assign top  = grp_top(ptr, G2_TOP);

  always_comb begin
    ptr_n = ptr;
    col_n = col;
    if (addr_ld) begin
      ptr_n = addr_in;
      col_n = r2_sc;
    end else begin
      if (step && ptr < top) ptr_n = ptr + 1'b1;
      if (wr_acc && ptr == AW'(A_PAGE)) col_n = wr_data[CW-1:0];
      else if (wr_acc && ptr == AW'(A_PRD)) col_n = col + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
      col <= '0;
    end else begin
      ptr <= ptr_n;
      col <= col_n;
    end
  end

  AST_LD_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    addr_ld |=> ptr == $past(addr_in)); // R7
  AST_PRD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (step && ptr == AW'(A_PRD)) |=> ptr == AW'(A_PRD)); // R2
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (ptr == $past(ptr) || ptr == $past(ptr) + 1'b1)); // R1
  AST_COL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && ptr == AW'(A_PRD)) |=> col == $past(col) + 1'b1); // R4
endmodule

// File: rtl/rb_regfile.sv
module rb_regfile
  import regbank_pkg::*;
#(
  parameter int NREG = 14,
  parameter int NCOL = 8,
  parameter int CW   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_acc,
  input  logic [AW-1:0]      ptr,
  input  logic [CW-1:0]      col,
  input  logic [DW-1:0]      wr_data,
  output logic [NREG*DW-1:0] regs_flat,
  output logic [DW-1:0]      alt_q,
  output logic [NCOL*DW-1:0] pr_flat
);
  logic alt_sel;
  logic alt_we;
  logic prd_we;

  assign alt_sel = regs_flat[0];
  assign alt_we  = wr_acc && ptr == AW'(A_ALT) && alt_sel;
  assign prd_we  = wr_acc && ptr == AW'(A_PRD);

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic we;
    assign we = wr_acc && ptr == AW'(i) && !(i == A_ALT && alt_sel);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  regs_flat[i*DW +: DW] <= rst_val(i);
      else if (we) regs_flat[i*DW +: DW] <= wr_data & wmask(i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      alt_q <= '0;
    else if (alt_we) alt_q <= wr_data;
  end

  for (genvar j = 0; j < NCOL; j++) begin : g_ent
    logic we;
    assign we = prd_we && col == CW'(j);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  pr_flat[j*DW +: DW] <= '0;
      else if (we) pr_flat[j*DW +: DW] <= wr_data & wmask(A_PRD);
    end
  end

  AST_FIXED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    regs_flat[1*DW+7] == 1'b0 && regs_flat[2*DW+3] == 1'b0 &&
    regs_flat[3*DW+5 +: 3] == 3'b000); // R5
  AST_ALT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    alt_we |=> $stable(regs_flat[A_ALT*DW +: DW])); // R6
  AST_HIGH_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && ptr >= AW'(NREG)) |=> ($stable(regs_flat) && $stable(alt_q) && $stable(pr_flat))); // R8
endmodule

// File: rtl/rb_readmux.sv
module rb_readmux
  import regbank_pkg::*;
#(
  parameter int NREG = 14
) (
  input  logic [AW-1:0]      ptr,
  input  logic [NREG*DW-1:0] regs_flat,
  input  logic [DW-1:0]      alt_q,
  output logic [DW-1:0]      rd_data
);
  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NREG; i++) begin
      if (ptr == AW'(i)) rd_data = regs_flat[i*DW +: DW];
    end
    if (ptr == AW'(A_ALT) && regs_flat[0]) rd_data = alt_q;
  end
endmodule

// File: rtl/ctrl_regbank.sv
module ctrl_regbank
  import regbank_pkg::*;
#(
  parameter int NREG   = 14,
  parameter int NCOL   = 8,
  parameter int G2_TOP = 13
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               addr_ld,
  input  logic [3:0]         addr_in,
  input  logic               wr_en,
  input  logic [7:0]         wr_data,
  input  logic               rd_en,
  output logic [7:0]         rd_data,
  output logic [NREG*8-1:0]  cfg_flat,
  output logic [7:0]         alt11_q,
  output logic [NCOL*8-1:0]  pr_flat
);
  localparam int CW = $clog2(NCOL);

  logic          wr_acc;
  logic          rd_acc;
  logic [AW-1:0] ptr;
  logic [CW-1:0] col;

  assign wr_acc = wr_en & ~addr_ld;
  assign rd_acc = rd_en & ~addr_ld & ~wr_en;

  rb_pointer #(.G2_TOP(G2_TOP), .CW(CW)) u_ptr (
    .clk(clk), .rst_n(rst_n), .addr_ld(addr_ld), .addr_in(addr_in),
    .wr_acc(wr_acc), .rd_acc(rd_acc), .wr_data(wr_data),
    .r2_sc(cfg_flat[A_PAGE*DW +: CW]), .ptr(ptr), .col(col)
  );

  rb_regfile #(.NREG(NREG), .NCOL(NCOL), .CW(CW)) u_rf (
    .clk(clk), .rst_n(rst_n), .wr_acc(wr_acc), .ptr(ptr), .col(col),
    .wr_data(wr_data), .regs_flat(cfg_flat), .alt_q(alt11_q), .pr_flat(pr_flat)
  );

  rb_readmux #(.NREG(NREG)) u_rd (
    .ptr(ptr), .regs_flat(cfg_flat), .alt_q(alt11_q), .rd_data(rd_data)
  );

  AST_HIGH_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && ptr >= AW'(NREG)) |-> rd_data == 8'h00); // R8
endmodule

// File: tb/ctrl_regbank_tb.sv
module ctrl_regbank_tb;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         addr_ld, wr_en, rd_en;
  logic [3:0]   addr_in;
  logic [7:0]   wr_data;
  logic [7:0]   rd_data;
  logic [111:0] cfg_flat;
  logic [7:0]   alt11_q;
  logic [63:0]  pr_flat;

  int n_run = 0;
  int n_fail = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;

  ctrl_regbank u_dut (
    .clk(clk), .rst_n(rst_n), .addr_ld(addr_ld), .addr_in(addr_in),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .cfg_flat(cfg_flat), .alt11_q(alt11_q), .pr_flat(pr_flat)
  );

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] reg_of(input int i);
    return cfg_flat[i*8 +: 8];
  endfunction
  function automatic logic [7:0] ent_of(input int j);
    return pr_flat[j*8 +: 8];
  endfunction

  task automatic op_ld(input logic [3:0] a);
    addr_ld = 1'b1; addr_in = a;
    @(posedge clk); #1 addr_ld = 1'b0;
  endtask
  task automatic op_wr(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    @(posedge clk); #1 wr_en = 1'b0;
  endtask
  task automatic op_rd(input logic [7:0] e, input string tag);
    exp_q.push_back(e); tag_q.push_back(tag);
    rd_en = 1'b1;
    @(posedge clk); #1 rd_en = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n && rd_en) begin
      if (exp_q.size() == 0) chk("R9 unexpected read", 128'(rd_data), 128'hX);
      else chk(tag_q.pop_front(), 128'(rd_data), 128'(exp_q.pop_front()));
    end
  end

  task automatic chk_reset();
    for (int i = 0; i < 14; i++)
      chk($sformatf("R3 reset reg%0d", i), 128'(reg_of(i)),
          128'((i == 1 || i == 5 || i == 6) ? 8'h03 : 8'h00));
    chk("R3 reset alt", 128'(alt11_q), 128'h0);
    chk("R3 reset entries", 128'(pr_flat), 128'h0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [111:0] snap_cfg;
    logic [63:0]  snap_pr;
    rst_n = 1'b0; addr_ld = 0; wr_en = 0; rd_en = 0; addr_in = 0; wr_data = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    chk_reset();

    // group 0..3, masks, column stepping from R2 start column 5
    op_ld(4'd0);
    op_wr(8'h00);
    op_wr(8'hFF);
    op_wr(8'h45);
    op_wr(8'hAA);
    op_wr(8'h31);
    op_wr(8'h07);
    op_wr(8'h1F);
    chk("R5 reg1 bit7 zero", 128'(reg_of(1)), 128'h7F);
    chk("R1 reg2 via advance", 128'(reg_of(2)), 128'h45);
    chk("R4 entry5", 128'(ent_of(5)), 128'h0A);
    chk("R4 entry6", 128'(ent_of(6)), 128'h11);
    chk("R4 entry7", 128'(ent_of(7)), 128'h07);
    chk("R4 entry0 wrap", 128'(ent_of(0)), 128'h1F);
    chk("R4 reg3 last", 128'(reg_of(3)), 128'h1F);

    op_ld(4'd0);
    op_rd(8'h00, "R9 read reg0");
    op_rd(8'h7F, "R1 read reg1");
    op_rd(8'h45, "R1 read reg2");
    op_rd(8'h1F, "R2 read reg3");
    op_rd(8'h1F, "R2 reg3 holds");

    // group 4..7
    op_ld(4'd4);
    op_wr(8'h11); op_wr(8'h22); op_wr(8'h33); op_wr(8'h44); op_wr(8'h55);
    chk("R1 reg4", 128'(reg_of(4)), 128'h11);
    chk("R2 reg7 top", 128'(reg_of(7)), 128'h55);
    chk("R2 reg8 untouched", 128'(reg_of(8)), 128'h00);
    op_ld(4'd6);
    op_rd(8'h33, "R1 read reg6");
    op_rd(8'h55, "R1 read reg7");
    op_rd(8'h55, "R2 read reg7 stays");

    // group 8..13
    op_ld(4'd8);
    for (int k = 0; k < 7; k++) op_wr(8'h80 + 8'(k));
    chk("R1 reg11", 128'(reg_of(11)), 128'h83);
    chk("R1 reg12", 128'(reg_of(12)), 128'h84);
    chk("R2 reg13 top", 128'(reg_of(13)), 128'h86);

    // alternate register at 11
    op_ld(4'd0); op_wr(8'h01);
    op_ld(4'd11); op_wr(8'h5A);
    chk("R6 alt written", 128'(alt11_q), 128'h5A);
    chk("R6 primary kept", 128'(reg_of(11)), 128'h83);
    op_ld(4'd11);
    op_rd(8'h5A, "R6 read alt");
    op_ld(4'd0); op_wr(8'h00);
    op_ld(4'd11);
    op_rd(8'h83, "R6 read primary");

    // address load reloads column (R2 start column 5)
    op_ld(4'd3); op_wr(8'h02);
    chk("R7 column reload", 128'(ent_of(5)), 128'h02);
    op_ld(4'd9);
    op_rd(8'h81, "R7 pointer load");

    // R2 write with reserved bit, column reload from data
    op_ld(4'd2); op_wr(8'h0F);
    chk("R5 reg2 bit3 zero", 128'(reg_of(2)), 128'h07);
    op_wr(8'hE3);
    chk("R7 column from R2 write", 128'(ent_of(7)), 128'h03);

    // out-of-range addresses
    snap_cfg = cfg_flat; snap_pr = pr_flat;
    op_ld(4'd14); op_wr(8'hFF);
    chk("R8 regs unchanged", 128'(cfg_flat), 128'(snap_cfg));
    chk("R8 entries unchanged", 128'(pr_flat), 128'(snap_pr));
    chk("R8 alt unchanged", 128'(alt11_q), 128'h5A);
    op_rd(8'h00, "R8 read 14");
    op_rd(8'h00, "R8 read 14 again");
    op_ld(4'd15);
    op_rd(8'h00, "R8 read 15");

    // reset mid-run
    @(posedge clk); #2 rst_n = 1'b0;
    #3 chk_reset();
    @(posedge clk); #1 rst_n = 1'b1;
    op_ld(4'd1);
    op_rd(8'h03, "R3 read reg1 after reset");

    @(posedge clk); #1;
    chk("R9 scoreboard drained", 128'(exp_q.size()), 128'h0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule